// File: doc/BRIEF.md
# Integer Issue Pipe Steering Allocator

This block sits between decode and the integer execution pipes. On every clock it looks at up to four decoded integer instructions, each tagged with an operation class, and steers each one onto one of four execution pipes: two upper pipes and two lower pipes, arranged as two symmetric upper/lower clusters. Each class may run only on certain pipes. The allocator grants slots strictly in program order. For each slot it reports whether that slot was granted, which pipe it received and the nominal result latency that a downstream scoreboard should expect. A slot that is not granted is simply not issued; the front end presents it again in a later cycle.

Two classes need extra care. A conditional move holds its pipe for two consecutive cycles, so the allocator keeps a one-cycle reservation and masks that pipe in the following cycle. A multi class instruction needs every pipe at once, so it issues only when all four pipes are free and no earlier slot has been granted, and nothing after it issues in that cycle.

Top module: `int_issue_steer`

## Requirements
- R1: While `rst_n` is low no slot is granted and any held pipe reservation is cleared. An ungranted slot reports pipe 0 and latency 0, and a slot whose valid bit is low is never granted.
- R2: Class codes (4 bits) and the pipes they may use, with pipe index 0 = upper-0, 1 = upper-1, 2 = lower-0, 3 = lower-1: 0 arith (any pipe), 1 load and 2 store (2 or 3), 3 shift and 4 branch (0 or 1), 5 multiply (1 only), 6 media (0 only), 7 call (2 only), 8 barrier (3 only), 9 conditional move (any pipe), 10 multi. Codes 11 to 15 behave as arith.
- R3: When a slot may use more than one free pipe, it receives the lowest-numbered one.
- R4: Slots are considered in order 0 to 3. Once a valid slot fails to get a pipe, no higher slot is granted in that cycle. Invalid slots are skipped and block nothing.
- R5: Within one cycle, no two granted slots receive the same pipe.
- R6: A multi instruction is granted only when all four pipes are free and no lower slot has been granted. When granted it reports pipe 0 and claims every pipe, so no higher slot is granted in that cycle.
- R7: A granted conditional move keeps its pipe reserved for exactly the next cycle. In that cycle the pipe is not given to any slot, and a multi instruction is not granted.
- R8: Reported latency of a granted slot: 7 for multiply, 3 for media, 2 for conditional move, and 1 for every other class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_valid | input | NUM_SLOTS | Per-slot request flag, bit i for slot i |
| slot_class | input | NUM_SLOTS*4 | Class code of slot i in bits [4i+3:4i] |
| slot_grant | output | NUM_SLOTS | Slot i issued this cycle |
| slot_pipe | output | NUM_SLOTS*2 | Pipe index of slot i in bits [2i+1:2i] |
| slot_lat | output | NUM_SLOTS*4 | Nominal latency of slot i in bits [4i+3:4i] |

## Verification
The hardest state to reach from the ports is a conditional-move reservation that collides with the next cycle's requests. The reserved pipe has to be the only pipe a constrained class may use, or the next cycle has to carry a multi instruction that must then wait. Directed pairs of cycles first set such a reservation and then send exactly the class that runs into it. After that, a long stream of random classes (conditional moves and multi included) and random valid patterns is checked every cycle against a behavioural model that tracks its own reservation, with occasional reset pulses that must clear it.

// File: rtl/issue_steer_pkg.sv
`timescale 1ns/1ps
// issue_steer_pkg: shared constants, class codes and per-class tables for
// the integer issue steering allocator.
// Assumes four integer pipes with index 0/1 = upper, 2/3 = lower.
package issue_steer_pkg;

    localparam int NPIPE   = 4;
    localparam int PIPE_W  = $clog2(NPIPE);
    localparam int CLASS_W = 4;
    localparam int LAT_W   = 4;

    typedef enum logic [CLASS_W-1:0] {
        OPC_ARITH   = 4'd0,
        OPC_LOAD    = 4'd1,
        OPC_STORE   = 4'd2,
        OPC_SHIFT   = 4'd3,
        OPC_BRANCH  = 4'd4,
        OPC_IMUL    = 4'd5,
        OPC_MEDIA   = 4'd6,
        OPC_CALL    = 4'd7,
        OPC_BARRIER = 4'd8,
        OPC_CMOV    = 4'd9,
        OPC_MULTI   = 4'd10
    } op_class_e;

    // Pipe eligibility mask, bit p set when pipe p may take the class.
    function automatic logic [NPIPE-1:0] class_pipe_mask(input logic [CLASS_W-1:0] cls);
        case (cls)
            OPC_LOAD, OPC_STORE:   return 4'b1100;
            OPC_SHIFT, OPC_BRANCH: return 4'b0011;
            OPC_IMUL:              return 4'b0010;
            OPC_MEDIA:             return 4'b0001;
            OPC_CALL:              return 4'b0100;
            OPC_BARRIER:           return 4'b1000;
            default:               return 4'b1111;
        endcase
    endfunction

    // Nominal result latency reported to the scoreboard.
    function automatic logic [LAT_W-1:0] class_latency(input logic [CLASS_W-1:0] cls);
        case (cls)
            OPC_IMUL:  return LAT_W'(7);
            OPC_MEDIA: return LAT_W'(3);
            OPC_CMOV:  return LAT_W'(2);
            default:   return LAT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/steer_class_decode.sv
`timescale 1ns/1ps
// steer_class_decode: turns one slot's class code into its pipe mask,
// latency and the two special-handling flags (multi, conditional move).
// Assumes reserved codes fall back to arith behaviour through the tables.
module steer_class_decode
    import issue_steer_pkg::*;
(
    input  logic [CLASS_W-1:0] cls,
    output logic [NPIPE-1:0]   elig,
    output logic [LAT_W-1:0]   lat,
    output logic               is_multi,
    output logic               is_cmov
);

    // Table lookup and flag decode for the slot.
    always_comb begin
        elig     = class_pipe_mask(cls);
        lat      = class_latency(cls);
        is_multi = (cls == OPC_MULTI);
        is_cmov  = (cls == OPC_CMOV);
    end

endmodule

// File: rtl/steer_slot_chain.sv
`timescale 1ns/1ps
// steer_slot_chain: in-order pipe picker. Walks the slots from 0 upward,
// passing a free-pipe vector and a stop flag from slot to slot. A slot takes
// the lowest free eligible pipe; a multi slot takes all pipes only if every
// pipe is still free. The first valid slot that fails stops the chain.
// Assumes free_in already excludes pipes reserved from the previous cycle.
module steer_slot_chain
    import issue_steer_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0]            valid,
    input  logic [NUM_SLOTS-1:0][NPIPE-1:0] elig,
    input  logic [NUM_SLOTS-1:0]            is_multi,
    input  logic [NPIPE-1:0]                free_in,
    output logic [NUM_SLOTS-1:0]            grant,
    output logic [NUM_SLOTS-1:0][NPIPE-1:0] pick_oh
);

    localparam logic [NPIPE-1:0] ALL_PIPES = '1;
    localparam logic [NPIPE-1:0] ONE       = NPIPE'(1);

    logic [NUM_SLOTS:0][NPIPE-1:0] free_c;
    logic [NUM_SLOTS:0]            stop_c;

    assign free_c[0] = free_in;
    assign stop_c[0] = 1'b0;

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
        logic [NPIPE-1:0] avail;
        logic [NPIPE-1:0] lowest;
        logic             ok;

        // Eligibility against the pipes still free and the grant decision.
        always_comb begin
            avail  = free_c[gi] & elig[gi];
            lowest = avail & (~avail + ONE);
            if (is_multi[gi]) begin
                ok = valid[gi] && !stop_c[gi] && (free_c[gi] == ALL_PIPES);
            end else begin
                ok = valid[gi] && !stop_c[gi] && (avail != '0);
            end
        end

        assign grant[gi]    = ok;
        assign pick_oh[gi]  = !ok ? '0 : (is_multi[gi] ? ALL_PIPES : lowest);
        assign free_c[gi+1] = free_c[gi] & ~pick_oh[gi];
        assign stop_c[gi+1] = stop_c[gi] | (valid[gi] & ~ok) | (ok & is_multi[gi]);
    end

endmodule

// File: rtl/steer_cmov_carry.sv
`timescale 1ns/1ps
// steer_cmov_carry: one-cycle reservation register for the second cycle of
// conditional moves. Each bit marks a pipe that must stay unused next cycle.
// Assumes the set mask is already limited to granted conditional moves.
module steer_cmov_carry
    import issue_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIPE-1:0] set_mask,
    output logic [NPIPE-1:0] carry_q
);

    // Capture this cycle's reservations; they live for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= '0;
        end else begin
            carry_q <= set_mask;
        end
    end

endmodule

// File: rtl/int_issue_steer.sv
`timescale 1ns/1ps
// int_issue_steer: top of the integer issue steering allocator. Decodes each
// slot's class, runs the in-order picker over the pipes left free by the
// conditional-move reservation, and reports grant, pipe index and latency.
// Assumes the front end re-presents any slot that is not granted.
module int_issue_steer
    import issue_steer_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SLOTS-1:0]         slot_valid,
    input  logic [NUM_SLOTS*CLASS_W-1:0] slot_class,
    output logic [NUM_SLOTS-1:0]         slot_grant,
    output logic [NUM_SLOTS*PIPE_W-1:0]  slot_pipe,
    output logic [NUM_SLOTS*LAT_W-1:0]   slot_lat
);

    logic [NUM_SLOTS-1:0][NPIPE-1:0] dec_elig;
    logic [NUM_SLOTS-1:0][LAT_W-1:0] dec_lat;
    logic [NUM_SLOTS-1:0]            dec_multi;
    logic [NUM_SLOTS-1:0]            dec_cmov;
    logic [NUM_SLOTS-1:0][NPIPE-1:0] pick_oh;
    logic [NUM_SLOTS-1:0]            grant_w;
    logic [NUM_SLOTS-1:0]            req_valid;
    logic [NPIPE-1:0]                carry_q;
    logic [NPIPE-1:0]                carry_set;
    logic [NUM_SLOTS-1:0][PIPE_W-1:0] pipe_idx;

    // Requests are masked while reset is held.
    assign req_valid = slot_valid & {NUM_SLOTS{rst_n}};

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_dec
        steer_class_decode u_dec (
            .cls      (slot_class[gi*CLASS_W +: CLASS_W]),
            .elig     (dec_elig[gi]),
            .lat      (dec_lat[gi]),
            .is_multi (dec_multi[gi]),
            .is_cmov  (dec_cmov[gi])
        );
    end

    steer_slot_chain #(.NUM_SLOTS(NUM_SLOTS)) u_chain (
        .valid    (req_valid),
        .elig     (dec_elig),
        .is_multi (dec_multi),
        .free_in  (~carry_q),
        .grant    (grant_w),
        .pick_oh  (pick_oh)
    );

    steer_cmov_carry u_carry (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (carry_set),
        .carry_q  (carry_q)
    );

    // Collect the pipes taken by granted conditional moves.
    always_comb begin
        carry_set = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (grant_w[i] && dec_cmov[i]) carry_set = carry_set | pick_oh[i];
        end
    end

    // Encode each slot's one-hot pick as the lowest set pipe index.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            pipe_idx[i] = '0;
            for (int p = NPIPE - 1; p >= 0; p--) begin
                if (pick_oh[i][p]) pipe_idx[i] = PIPE_W'(p);
            end
        end
    end

    // Drive the per-slot outputs; ungranted slots report zeros.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            slot_grant[i]                 = grant_w[i];
            slot_pipe[i*PIPE_W +: PIPE_W] = pipe_idx[i];
            slot_lat[i*LAT_W +: LAT_W]    = grant_w[i] ? dec_lat[i] : '0;
        end
    end

    // ---------------- assertions ----------------
    logic [NPIPE-1:0][2:0] pipe_hits;

    // Count, per reported pipe index, the granted single-pipe slots.
    always_comb begin
        pipe_hits = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_grant[i] && !dec_multi[i]) begin
                pipe_hits[slot_pipe[i*PIPE_W +: PIPE_W]] = pipe_hits[slot_pipe[i*PIPE_W +: PIPE_W]] + 3'd1;
            end
        end
    end

    AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_grant & ~slot_valid) == '0);  // R1

    for (genvar p = 0; p < NPIPE; p++) begin : g_ast_pipe
        AST_PIPE_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
            pipe_hits[p] <= 3'd1);  // R5
    end

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_ast_slot
        AST_PIPE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_grant[gi] && !dec_multi[gi]) |-> dec_elig[gi][slot_pipe[gi*PIPE_W +: PIPE_W]]);  // R2
        AST_CMOV_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_grant[gi] && !dec_multi[gi]) |-> !carry_q[slot_pipe[gi*PIPE_W +: PIPE_W]]);  // R7
        AST_MULTI_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_grant[gi] && dec_multi[gi]) |-> ($countones(slot_grant) == 1 && carry_q == '0));  // R6
        for (genvar gj = 0; gj < gi; gj++) begin : g_ord
            AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_valid[gj] && !slot_grant[gj]) |-> !slot_grant[gi]);  // R4
        end
    end

endmodule

// File: tb/tb_int_issue_steer.sv
`timescale 1ns/1ps
// Bench for int_issue_steer: behavioural per-cycle model compared on every
// cycle, plus directed expectations for the corner cases.
module tb_int_issue_steer;
    import issue_steer_pkg::*;

    localparam int NS = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NS-1:0]           slot_valid = '0;
    logic [NS*CLASS_W-1:0]   slot_class = '0;
    logic [NS-1:0]           slot_grant;
    logic [NS*PIPE_W-1:0]    slot_pipe;
    logic [NS*LAT_W-1:0]     slot_lat;

    int vectors = 0;
    int errors  = 0;
    int carry_m = 0;
    int next_m  = 0;
    int vin[NS];
    int cin[NS];
    int eg[NS];
    int ep[NS];
    int el[NS];
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    int_issue_steer #(.NUM_SLOTS(NS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_valid (slot_valid),
        .slot_class (slot_class),
        .slot_grant (slot_grant),
        .slot_pipe  (slot_pipe),
        .slot_lat   (slot_lat)
    );

    function automatic int mask_of(int c);
        case (c)
            1, 2:    return 12;
            3, 4:    return 3;
            5:       return 2;
            6:       return 1;
            7:       return 4;
            8:       return 8;
            default: return 15;
        endcase
    endfunction

    function automatic int lat_of(int c);
        case (c)
            5:       return 7;
            6:       return 3;
            9:       return 2;
            default: return 1;
        endcase
    endfunction

    // Reference model for one cycle; also computes the next reservation.
    task automatic model(input bit r);
        int  free;
        bit  stop;
        free   = 15 & ~carry_m;
        stop   = 1'b0;
        next_m = 0;
        for (int i = 0; i < NS; i++) begin
            int av;
            eg[i] = 0; ep[i] = 0; el[i] = 0;
            if (r && vin[i] != 0 && !stop) begin
                if (cin[i] == 10) begin
                    if (free == 15) begin
                        eg[i] = 1; el[i] = 1; free = 0;
                    end
                    stop = 1'b1;
                end else begin
                    av = free & mask_of(cin[i]);
                    if (av == 0) begin
                        stop = 1'b1;
                    end else begin
                        int p;
                        p = 0;
                        while (((av >> p) & 1) == 0) p++;
                        eg[i] = 1; ep[i] = p; el[i] = lat_of(cin[i]);
                        free = free & ~(1 << p);
                        if (cin[i] == 9) next_m = next_m | (1 << p);
                    end
                end
            end
        end
    endtask

    task automatic check_val(input int act, input int exp, input string tag, input string what, input int slot);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s slot %0d %s: actual=%0d expected=%0d at %0t", tag, slot, what, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus and compare every slot against the model.
    task automatic step(input bit r, input logic [NS-1:0] v,
                        input int c0, input int c1, input int c2, input int c3);
        @(negedge clk);
        carry_m = next_m;
        rst_n = r;
        slot_valid = v;
        slot_class = {4'(c3), 4'(c2), 4'(c1), 4'(c0)};
        cin[0] = c0; cin[1] = c1; cin[2] = c2; cin[3] = c3;
        for (int i = 0; i < NS; i++) vin[i] = int'(v[i]);
        #5;
        model(r);
        for (int i = 0; i < NS; i++) begin
            check_val(int'(slot_grant[i]), eg[i], "R4", "grant", i);
            check_val(int'(slot_pipe[i*PIPE_W +: PIPE_W]), ep[i], "R3", "pipe", i);
            check_val(int'(slot_lat[i*LAT_W +: LAT_W]), el[i], "R8", "latency", i);
        end
    endtask

    // Directed expectation on the outputs of the cycle just applied.
    task automatic want(input int slot, input int g, input int p, input int l, input string tag);
        check_val(int'(slot_grant[slot]), g, tag, "grant", slot);
        if (g != 0) begin
            check_val(int'(slot_pipe[slot*PIPE_W +: PIPE_W]), p, tag, "pipe", slot);
            check_val(int'(slot_lat[slot*LAT_W +: LAT_W]), l, tag, "latency", slot);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset held with full requests, including a conditional move.
        step(1'b0, 4'b1111, 9, 0, 0, 0);
        want(0, 0, 0, 0, "R1"); want(3, 0, 0, 0, "R1");
        step(1'b0, 4'b1111, 9, 9, 0, 0);
        // R1/R6: after reset all pipes are free, so multi in slot 0 issues.
        step(1'b1, 4'b0011, 10, 0, 0, 0);
        want(0, 1, 0, 1, "R6"); want(1, 0, 0, 0, "R6");
        // R3: four arith take pipes in ascending order.
        step(1'b1, 4'b1111, 0, 0, 0, 0);
        want(0, 1, 0, 1, "R3"); want(3, 1, 3, 1, "R3");
        // R2/R4: two loads fill the lower pipes; the store fails and stops slot 3.
        step(1'b1, 4'b1111, 1, 1, 2, 0);
        want(0, 1, 2, 1, "R2"); want(1, 1, 3, 1, "R2");
        want(2, 0, 0, 0, "R4"); want(3, 0, 0, 0, "R4");
        // R2: shift and branch use the upper pair.
        step(1'b1, 4'b0011, 3, 4, 0, 0);
        want(0, 1, 0, 1, "R2"); want(1, 1, 1, 1, "R2");
        // R2/R8: multiply on upper-1 and media on upper-0 with their latencies.
        step(1'b1, 4'b0011, 5, 6, 0, 0);
        want(0, 1, 1, 7, "R8"); want(1, 1, 0, 3, "R8");
        // R2: call on lower-0, barrier on lower-1.
        step(1'b1, 4'b0011, 8, 7, 0, 0);
        want(0, 1, 3, 1, "R2"); want(1, 1, 2, 1, "R2");
        // R6: multi behind a granted arith must wait and stop slot 2.
        step(1'b1, 4'b0111, 0, 10, 0, 0);
        want(0, 1, 0, 1, "R6"); want(1, 0, 0, 0, "R6"); want(2, 0, 0, 0, "R6");
        // R6: granted multi claims everything.
        step(1'b1, 4'b0011, 10, 0, 0, 0);
        want(0, 1, 0, 1, "R6"); want(1, 0, 0, 0, "R6");
        // R7: conditional move reserves pipe 0 for the next cycle only.
        step(1'b1, 4'b0001, 9, 0, 0, 0);
        want(0, 1, 0, 2, "R7");
        step(1'b1, 4'b1111, 0, 0, 0, 0);
        want(0, 1, 1, 1, "R7"); want(2, 1, 3, 1, "R7"); want(3, 0, 0, 0, "R7");
        step(1'b1, 4'b1111, 0, 0, 0, 0);
        want(0, 1, 0, 1, "R7"); want(3, 1, 3, 1, "R7");
        // R7: media needs upper-0, held by a conditional move from last cycle.
        step(1'b1, 4'b0001, 9, 0, 0, 0);
        step(1'b1, 4'b0011, 6, 0, 0, 0);
        want(0, 0, 0, 0, "R7"); want(1, 0, 0, 0, "R4");
        // R7/R6: reservation blocks a multi, then the multi issues.
        step(1'b1, 4'b0011, 9, 9, 0, 0);
        step(1'b1, 4'b0001, 10, 0, 0, 0);
        want(0, 0, 0, 0, "R7");
        step(1'b1, 4'b0001, 10, 0, 0, 0);
        want(0, 1, 0, 1, "R6");
        // R4: invalid slots are skipped without blocking.
        step(1'b1, 4'b1010, 0, 0, 0, 0);
        want(0, 0, 0, 0, "R4"); want(1, 1, 0, 1, "R4"); want(3, 1, 1, 1, "R4");
        // R2/R8: reserved codes act as arith.
        step(1'b1, 4'b0011, 15, 11, 0, 0);
        want(0, 1, 0, 1, "R2"); want(1, 1, 1, 1, "R8");
        // R1: reset clears a pending reservation.
        step(1'b1, 4'b0001, 9, 0, 0, 0);
        step(1'b0, 4'b0000, 0, 0, 0, 0);
        step(1'b1, 4'b0001, 10, 0, 0, 0);
        want(0, 1, 0, 1, "R1");
        // R5/R3/R4/R7: random stream checked against the model.
        for (int n = 0; n < 4000; n++) begin
            step(($urandom_range(0, 150) != 0), 4'($urandom_range(0, 15)),
                 $urandom_range(0, 15), $urandom_range(0, 15),
                 $urandom_range(0, 15), $urandom_range(0, 15));
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule